// File: doc/BRIEF.md
# Transmit Commit Buffer for a High-Speed UART

This block holds the bytes a UART is about to send. The host writes bytes into a RAM window. The window's byte offsets count from the current write pointer, so the host can stage a batch without tracking where the ring wraps. Staged bytes stay hidden. They become visible only when the host writes a byte count to the commit register. That write publishes exactly that many bytes and moves the write pointer past them.

On the other side, a serializer sees the oldest committed byte together with a valid flag. It takes bytes one at a time with a pop strobe. The block also provides three things: a control read-back word that holds the committed fill and the write pointer, an empty flag, and a space request. The space request stays high while the fill is below a level chosen by a small configuration code.

Top module: `uart_txbuf`

## Requirements
- R1: After reset the fill and write pointer are 0, `tx_empty` is 1, `ser_valid` is 0, the trigger code is 5 and `space_req` is 1.
- R2: A host write with byte address 0x400+i (i a multiple of 4, below 1024) stores each enabled lane j (`bus_wdata[8j+7:8j]`) at ring index (wptr+i+j) mod 1024. It does not change the fill, the write pointer or `ser_valid`.
- R3: A write to address 0x804 with `bus_be[1:0]` = 2'b11 commits N = `bus_wdata[9:0]` bytes. The fill grows by N and the write pointer advances by N modulo 1024, both visible on the next cycle.
- R4: The block never holds more than 1020 committed bytes. A commit larger than 1020 minus the current fill is reduced to that amount, and a commit at full fill has no effect.
- R5: `ctl_rdata` carries the fill in bits 25:16 and the write pointer in bits 9:0. All other bits are 0.
- R6: `ser_byte` is the oldest committed byte. A pop while `ser_valid` is 1 removes it, and the fill drops by one on the next cycle. A pop while empty changes nothing.
- R7: When a commit and a valid pop land in the same cycle, the new fill is fill + N' - 1. N' is the commit clamped against the fill before the pop.
- R8: A write to address 0x808 with `bus_be[2]` set loads the trigger code k from `bus_wdata[18:16]`. `space_req` is 1 exactly while the fill is below 4 << k (so code 5 means 128 bytes).
- R9: `tx_empty` is 1 exactly when the fill is 0, and `ser_valid` is its inverse.
- R10: Read and write pointers wrap modulo 1024, so committed data that crosses the end of the ring comes out in commit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 12 | Host byte address (word aligned) |
| bus_wdata | input | 32 | Host write data |
| bus_be | input | 4 | Host byte-lane enables |
| ctl_rdata | output | 32 | Fill count and write pointer word |
| ser_pop | input | 1 | Serializer takes the current byte |
| ser_valid | output | 1 | A committed byte is available |
| ser_byte | output | 8 | Oldest committed byte |
| space_req | output | 1 | Fill is below the trigger level |
| tx_empty | output | 1 | No committed bytes remain |

## Verification
The hardest state to reach is a commit that arrives together with a pop while the ring is full and its pointers have already wrapped. In that state the clamp has to use the fill from before the pop. To get there, the stimulus first stages a full 1024-byte window and requests 1023 bytes, which the clamp cuts to 1020. It then issues commits at full fill, with and without a pop in the same cycle. A scoreboard tracks every committed byte, so the drain that follows checks the order across the wrap byte by byte.

// File: rtl/uart_txbuf.sv
module uart_txbuf #(
  parameter int PTR_W     = 10,
  parameter int HOLD_MAX  = 1020,
  parameter int ADDR_W    = 12,
  parameter int TRIG_W    = 3,
  parameter logic [ADDR_W-1:0] WIN_BASE = 12'h400,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 12'h804,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 12'h808,
  parameter logic [TRIG_W-1:0] TRIG_RST = 3'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  output logic [31:0]       ctl_rdata,
  input  logic              ser_pop,
  output logic              ser_valid,
  output logic [7:0]        ser_byte,
  output logic              space_req,
  output logic              tx_empty
);
  localparam int DEPTH = 1 << PTR_W;
  localparam int THR_W = PTR_W + 3;
  localparam logic [PTR_W-1:0] CAP = PTR_W'(HOLD_MAX);

  logic [7:0]        ring [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr, fill;
  logic [TRIG_W-1:0] trig;

  logic              win_hit, commit_en, cfg_en, pop_ok;
  logic [ADDR_W-1:0] win_rel;
  logic [PTR_W-1:0]  win_off, room, n_req, n_eff;
  logic [THR_W-1:0]  thresh;

  assign win_rel   = bus_addr - WIN_BASE;
  assign win_hit   = bus_wr && (bus_addr >= WIN_BASE) && (win_rel < ADDR_W'(DEPTH));
  assign win_off   = {win_rel[PTR_W-1:2], 2'b00};
  assign commit_en = bus_wr && (bus_addr == CTL_ADDR) && (bus_be[1:0] == 2'b11);
  assign cfg_en    = bus_wr && (bus_addr == CFG_ADDR) && bus_be[2];

  assign room   = CAP - fill;
  assign n_req  = bus_wdata[PTR_W-1:0];
  assign n_eff  = commit_en ? ((n_req > room) ? room : n_req) : '0;
  assign pop_ok = ser_pop && (fill != '0);

  always_ff @(posedge clk) begin
    for (int j = 0; j < 4; j++) begin
      if (win_hit && bus_be[j])
        ring[wptr + win_off + PTR_W'(j)] <= bus_wdata[8*j +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
      trig <= TRIG_RST;
    end else begin
      wptr <= wptr + n_eff;
      rptr <= rptr + PTR_W'(pop_ok);
      fill <= fill + n_eff - PTR_W'(pop_ok);
      if (cfg_en)
        trig <= bus_wdata[16 +: TRIG_W];
    end
  end

  assign thresh    = THR_W'(4) << trig;
  assign space_req = THR_W'(fill) < thresh;
  assign tx_empty  = (fill == '0);
  assign ser_valid = !tx_empty;
  assign ser_byte  = ring[rptr];

  always_comb begin
    ctl_rdata = '0;
    ctl_rdata[16 +: PTR_W] = fill;
    ctl_rdata[0 +: PTR_W]  = wptr;
  end

  AST_FILL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CAP); // R4
  AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    PTR_W'(wptr - rptr) == fill); // R10
  AST_CLAMP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en && !ser_pop && (n_req >= room) |=> fill == CAP); // R4
  AST_IDLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    ser_pop && tx_empty && !commit_en |=> tx_empty && $stable(rptr)); // R6
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ser_pop && !tx_empty && !commit_en |=> fill == $past(fill) - 1'b1); // R6
  AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_en |=> $stable(wptr)); // R2
endmodule

// File: tb/uart_txbuf_tb_top.sv
module uart_txbuf_tb_top;
  localparam int CLK_P = 10;
  localparam int CAP   = 1020;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] ctl_rdata;
  logic        ser_pop = 0;
  logic        ser_valid;
  logic [7:0]  ser_byte;
  logic        space_req;
  logic        tx_empty;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mdl_mem [1024];
  int mdl_wptr = 0;
  int mdl_fill = 0;
  logic [7:0] exp_q [$];

  always #(CLK_P/2) clk = ~clk;

  uart_txbuf dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .ctl_rdata(ctl_rdata),
    .ser_pop(ser_pop), .ser_valid(ser_valid), .ser_byte(ser_byte),
    .space_req(space_req), .tx_empty(tx_empty)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && ser_pop && ser_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R6 pop with empty scoreboard actual=%h expected=none", ser_byte);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (ser_byte !== e) begin
          fails++;
          $display("FAIL R6/R10 byte order actual=%h expected=%h", ser_byte, e);
        end
      end
      mdl_fill--;
    end
  end

  task automatic bus_write(logic [11:0] a, logic [31:0] d, logic [3:0] be, bit pop);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be; ser_pop = pop;
    @(posedge clk); #1;
    bus_wr = 0; bus_be = '0; ser_pop = 0;
  endtask

  task automatic win_write(int off, logic [31:0] d, logic [3:0] be);
    for (int j = 0; j < 4; j++)
      if (be[j]) mdl_mem[(mdl_wptr + off + j) % 1024] = d[8*j +: 8];
    bus_write(12'h400 + 12'(off), d, be, 0);
  endtask

  task automatic commit(int n, bit pop);
    int eff;
    eff = (n > CAP - mdl_fill) ? CAP - mdl_fill : n;
    for (int k = 0; k < eff; k++) exp_q.push_back(mdl_mem[(mdl_wptr + k) % 1024]);
    mdl_wptr = (mdl_wptr + eff) % 1024;
    mdl_fill += eff;
    bus_write(12'h804, 32'(n), 4'b0011, pop);
  endtask

  task automatic set_trig(logic [2:0] k);
    bus_write(12'h808, {13'b0, k, 16'b0}, 4'b0100, 0);
  endtask

  task automatic pop_n(int n);
    @(posedge clk); #1;
    ser_pop = 1;
    repeat (n) @(posedge clk);
    #1 ser_pop = 0;
  endtask

  function automatic logic [31:0] ctl_exp();
    return {6'b0, 10'(mdl_fill), 6'b0, 10'(mdl_wptr)};
  endfunction

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 ctl after reset", ctl_rdata, 32'h0);
    chk("R1 empty after reset", 32'(tx_empty), 32'd1);
    chk("R1 valid after reset", 32'(ser_valid), 32'd0);
    chk("R1 space_req after reset", 32'(space_req), 32'd1);

    win_write(0, 32'h44332211, 4'hF);
    win_write(4, 32'h88776655, 4'hF);
    @(negedge clk);
    chk("R2 staged bytes hidden", ctl_rdata, 32'h0);
    chk("R2 valid stays low", 32'(ser_valid), 32'd0);
    commit(8, 0);
    @(negedge clk);
    chk("R3 R5 ctl after commit 8", ctl_rdata, 32'h0008_0008);
    chk("R6 head byte", 32'(ser_byte), 32'h11);
    chk("R9 not empty", 32'(tx_empty), 32'd0);
    pop_n(8);
    @(negedge clk);
    chk("R9 empty after drain", 32'(tx_empty), 32'd1);
    chk("R5 ctl after drain", ctl_rdata, 32'h0000_0008);

    win_write(0, 32'hA3A2A1A0, 4'b0111);
    commit(3, 0);
    win_write(0, 32'hB3B2B1B0, 4'b1111);
    win_write(4, 32'hC3C2C1C0, 4'b0101);
    win_write(4, 32'h0000D100, 4'b0010);
    commit(7, 0);
    @(negedge clk);
    chk("R2 R3 unaligned ctl", ctl_rdata, 32'h000A_0012);
    pop_n(10);

    pop_n(3);
    @(negedge clk);
    chk("R6 idle pop ignored", ctl_rdata, 32'h0000_0012);
    chk("R6 idle pop empty", 32'(tx_empty), 32'd1);

    for (int k = 0; k < 32; k++) win_write(4 * k, 32'h01010101 * k ^ 32'h03020100, 4'hF);
    commit(127, 0);
    @(negedge clk);
    chk("R8 fill 127 below 128", 32'(space_req), 32'd1);
    commit(1, 0);
    @(negedge clk);
    chk("R8 fill 128 at level", 32'(space_req), 32'd0);
    chk("R5 ctl fill 128", ctl_rdata, 32'h0080_0092);
    set_trig(3'd7);
    @(negedge clk);
    chk("R8 code 7 level 512", 32'(space_req), 32'd1);
    set_trig(3'd0);
    @(negedge clk);
    chk("R8 code 0 level 4", 32'(space_req), 32'd0);
    set_trig(3'd5);
    pop_n(128);
    @(negedge clk);
    chk("R8 empty requests space", 32'(space_req), 32'd1);

    for (int k = 0; k < 256; k++) win_write(4 * k, 32'h5A3C0F00 ^ (32'h00010203 * k), 4'hF);
    commit(1023, 0);
    @(negedge clk);
    chk("R4 clamp to 1020", ctl_rdata, 32'h03FC_008E);
    commit(5, 0);
    @(negedge clk);
    chk("R4 commit at full ignored", ctl_rdata, 32'h03FC_008E);
    commit(5, 1);
    @(negedge clk);
    chk("R7 full commit with pop", ctl_rdata, 32'h03FB_008E);
    pop_n(1009);
    @(negedge clk);
    chk("R10 wrapped drain fill", ctl_rdata, ctl_exp());
    commit(3, 1);
    @(negedge clk);
    chk("R7 commit with pop", ctl_rdata, 32'h000C_0091);
    pop_n(12);
    @(negedge clk);
    chk("R9 final empty", 32'(tx_empty), 32'd1);
    chk("R6 scoreboard drained", 32'(exp_q.size()), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule